// File: doc/BRIEF.md
# External Interrupt Request Controller

This block watches six active-low interrupt request pins and turns them into per-channel interrupt requests for a processor. Each channel has two settings, held in two 8-bit registers on a simple synchronous register bus. An enable register gates the channel. A sense register chooses whether the channel requests while its pin is held low or latches a request on a falling edge.

Every pin passes through a two-stage synchronizer. Falling edges on edge-mode channels are caught in sticky status flags, which software clears by writing zeros to a third register. A channel's request is its level condition or its flag, masked by its enable bit. The OR of all channel requests gives a single combined request line.

A standby input forces every channel back to level sensing while it is high. The two top bits of the enable and sense registers only store data.

Top module: `extirq_ctrl`

## Requirements
- R1: While reset is low, and right after it, the enable, sense and status registers are all zero, no channel requests, and the combined request is low. The synchronizer stages reset to the idle-high value.
- R2: Bit n (n = 0..5) of the enable register gates channel n; a 0 keeps `chan_req[n]` low whatever the pin or flag does.
- R3: With sense bit n = 0 (level mode) and enable bit n = 1, `chan_req[n]` rises after the second clock edge following the pin going low. It falls after the second edge following the pin going high.
- R4: With sense bit n = 1 (edge mode), a synchronized sample of 1 followed by a sample of 0 sets status flag n on the third clock edge after the pin falls. The flag, and the request of an enabled channel, stay set after the pin returns high.
- R5: Writing address 2 clears each status flag whose data bit is 0 and leaves flags whose data bit is 1 unchanged. If an edge sets a flag on the same edge as a write that clears it, the flag ends up set.
- R6: Falling edges on an edge-mode channel set its flag even while the channel is disabled. Enabling the channel presents the pending request on the clock edge that completes the enable write.
- R7: Bits 7 and 6 of the enable and sense registers store written values and read back, but do not enable a channel or select a sense mode.
- R8: While `standby` is high, the sense register is forced to 0x00 at every clock edge, and writes to it have no effect.
- R9: `irq_any` is high exactly when at least one bit of `chan_req` is high.
- R10: With `reg_rd` high, `reg_rdata` returns all 8 bits of the enable register for address 0 and of the sense register for address 1. Address 2 returns the six flags in bits 5..0 with bits 7..6 zero, and address 3 returns zero. With `reg_rd` low, `reg_rdata` is zero. A register write is visible from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Forces the sense register to zero while high |
| irq_n | input | 6 | Active-low external request pins, one per channel |
| reg_addr | input | 2 | Register address: 0 enable, 1 sense, 2 status |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, combinational from address and strobe |
| chan_req | output | 6 | Per-channel interrupt requests |
| irq_any | output | 1 | OR of all channel requests |

## Verification
The risky overlap is a falling edge being latched into a status flag on the same clock edge that a software write clears that flag. The bench causes this by pulling a pin low and timing a status write of zero for the edge on which the synchronized edge is seen, and it expects the flag to survive. A second overlap, a sense-register write during standby, is driven and checked to read back zero. A behavioural reference model is compared with every output on every cycle, so both overlaps are also judged against the model.

// File: rtl/extirq_ctrl.sv
module extirq_ctrl #(
  parameter int NCH = 6,
  parameter int RW  = 8,
  parameter int AW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           standby,
  input  logic [NCH-1:0] irq_n,
  input  logic [AW-1:0]  reg_addr,
  input  logic           reg_wr,
  input  logic [RW-1:0]  reg_wdata,
  input  logic           reg_rd,
  output logic [RW-1:0]  reg_rdata,
  output logic [NCH-1:0] chan_req,
  output logic           irq_any
);
  localparam int RSV = RW - NCH;
  localparam logic [AW-1:0] A_EN = AW'(0);
  localparam logic [AW-1:0] A_SC = AW'(1);
  localparam logic [AW-1:0] A_ST = AW'(2);

  logic [RW-1:0]  en_q, sc_q;
  logic [NCH-1:0] s1, s2, s3, flag_q;
  logic [NCH-1:0] fall, flag_d;

  assign fall = s3 & ~s2;

  always_comb begin
    flag_d = flag_q;
    if (reg_wr && reg_addr == A_ST) flag_d = flag_d & reg_wdata[NCH-1:0];
    flag_d = flag_d | (fall & sc_q[NCH-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1     <= '1;
      s2     <= '1;
      s3     <= '1;
      en_q   <= '0;
      sc_q   <= '0;
      flag_q <= '0;
    end else begin
      s1     <= irq_n;
      s2     <= s1;
      s3     <= s2;
      flag_q <= flag_d;
      if (reg_wr && reg_addr == A_EN) en_q <= reg_wdata;
      if (standby)                         sc_q <= '0;
      else if (reg_wr && reg_addr == A_SC) sc_q <= reg_wdata;
    end
  end

  assign chan_req = en_q[NCH-1:0] &
                    ((sc_q[NCH-1:0] & flag_q) | (~sc_q[NCH-1:0] & ~s2));
  assign irq_any  = |chan_req;

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        A_EN:    reg_rdata = en_q;
        A_SC:    reg_rdata = sc_q;
        A_ST:    reg_rdata = {{RSV{1'b0}}, flag_q};
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

module extirq_ctrl_chk #(
  parameter int NCH = 6,
  parameter int RW  = 8,
  parameter int AW  = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           standby,
  input logic [AW-1:0]  reg_addr,
  input logic           reg_wr,
  input logic           reg_rd,
  input logic [RW-1:0]  reg_rdata,
  input logic [NCH-1:0] chan_req,
  input logic [RW-1:0]  en_q,
  input logic [RW-1:0]  sc_q,
  input logic [NCH-1:0] flag_q,
  input logic [NCH-1:0] s2,
  input logic [NCH-1:0] fall
);
  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_req & ~en_q[NCH-1:0]) == '0);

  a_r3_level_high_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_req & ~sc_q[NCH-1:0] & s2) == '0);

  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == AW'(2)) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(fall & sc_q[NCH-1:0]) & ~flag_q) == '0));

  a_r8_standby_level: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> sc_q == '0);

  a_r10_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> reg_rdata == '0);
endmodule

bind extirq_ctrl extirq_ctrl_chk #(.NCH(NCH), .RW(RW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby), .reg_addr(reg_addr),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
  .chan_req(chan_req), .en_q(en_q), .sc_q(sc_q), .flag_q(flag_q),
  .s2(s2), .fall(fall)
);

// File: tb/extirq_ctrl_test.sv
module extirq_ctrl_test;
  localparam int PERIOD = 10;

  logic       clk = 0, rst_n = 0, standby = 0;
  logic [5:0] irq_n = '1;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [5:0] chan_req;
  logic       irq_any;

  int tests = 0, fails = 0;
  bit done = 0;

  extirq_ctrl uut (.*);

  always #(PERIOD/2) clk = ~clk;

  // behavioural reference
  logic [7:0] m_en = 0, m_sc = 0;
  logic [5:0] m_fl = 0;
  logic [5:0] hist[$] = '{6'h3f, 6'h3f, 6'h3f};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_sc = 0; m_fl = 0;
      hist = '{6'h3f, 6'h3f, 6'h3f};
    end else begin
      logic [5:0] f, nf;
      f  = hist[0] & ~hist[1];
      nf = m_fl;
      if (reg_wr && reg_addr == 2) nf = nf & reg_wdata[5:0];
      nf = nf | (f & m_sc[5:0]);
      if (reg_wr && reg_addr == 0) m_en = reg_wdata;
      if (standby) m_sc = 0;
      else if (reg_wr && reg_addr == 1) m_sc = reg_wdata;
      m_fl = nf;
      hist.push_back(irq_n);
      void'(hist.pop_front());
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #(PERIOD/4);
    if (rst_n) begin
      logic [5:0] er;
      logic [7:0] ed;
      er = m_en[5:0] & ((m_sc[5:0] & m_fl) | (~m_sc[5:0] & ~hist[1]));
      ed = !reg_rd ? 8'h00 : reg_addr == 0 ? m_en : reg_addr == 1 ? m_sc :
           reg_addr == 2 ? {2'b00, m_fl} : 8'h00;
      chk("model chan_req R2 R3 R4", {2'b00, chan_req}, {2'b00, er});
      chk("model irq_any R9", {7'd0, irq_any}, {7'd0, |er});
      chk("model rdata R10", reg_rdata, ed);
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    step();
    reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
    reg_addr = a; reg_rd = 1;
    #1 chk(tag, reg_rdata, exp);
    reg_rd = 0;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    step();
    // R1 reset state
    rd(0, 8'h00, "R1 enable after reset");
    rd(1, 8'h00, "R1 sense after reset");
    rd(2, 8'h00, "R1 status after reset");
    chk("R1 no request", {2'b00, chan_req}, 8'h00);

    // R7 reserved enable bits do nothing; R2 disabled channel quiet
    wr(0, 8'hC0);
    irq_n[0] = 0;
    step(4);
    chk("R7 reserved enable no effect", {2'b00, chan_req}, 8'h00);
    chk("R2 disabled level channel quiet", {7'd0, irq_any}, 8'h00);
    rd(0, 8'hC0, "R7 reserved enable readback");

    // R3 level mode
    wr(0, 8'h01);
    chk("R3 level request", {2'b00, chan_req}, 8'h01);
    chk("R9 combined request", {7'd0, irq_any}, 8'h01);
    irq_n[0] = 1;
    step();
    chk("R3 request held one edge", {2'b00, chan_req}, 8'h01);
    step();
    chk("R3 request drops second edge", {2'b00, chan_req}, 8'h00);

    // R4 edge mode on channel 1, R7 reserved sense bits
    wr(1, 8'hC2);
    wr(0, 8'h03);
    irq_n[1] = 0;
    step(2);
    chk("R4 no flag before third edge", {2'b00, chan_req}, 8'h00);
    step();
    chk("R4 flag on third edge", {2'b00, chan_req}, 8'h02);
    irq_n[1] = 1;
    step(4);
    chk("R4 request sticky after pin high", {2'b00, chan_req}, 8'h02);
    rd(2, 8'h02, "R10 status readback");
    rd(1, 8'hC2, "R7 reserved sense readback");

    // R6 edge while disabled on channel 2
    wr(1, 8'h06);
    irq_n[2] = 0;
    step(4);
    irq_n[2] = 1;
    step(2);
    chk("R6 disabled edge no request", {2'b00, chan_req}, 8'h02);
    rd(2, 8'h06, "R6 flag set while disabled");
    wr(0, 8'h07);
    chk("R6 pending request on enable", {2'b00, chan_req}, 8'h06);

    // R5 clear: zero clears bit1, ones keep bit2
    wr(2, 8'hFD);
    rd(2, 8'h04, "R5 selective clear");
    chk("R5 request after clear", {2'b00, chan_req}, 8'h04);
    wr(2, 8'h00);
    rd(2, 8'h00, "R5 clear all");

    // R5 set wins over clear on the same edge
    irq_n[1] = 0;
    step(2);
    reg_addr = 2; reg_wdata = 8'h00; reg_wr = 1;
    step();
    reg_wr = 0;
    rd(2, 8'h02, "R5 set wins over clear");
    irq_n[1] = 1;
    step(3);

    // R8 standby
    wr(1, 8'hFF);
    rd(1, 8'hFF, "R7 sense all ones stored");
    standby = 1;
    step();
    rd(1, 8'h00, "R8 standby forces level");
    wr(1, 8'h3F);
    rd(1, 8'h00, "R8 write ignored in standby");
    standby = 0;
    step();

    // R10 unused address and idle read
    rd(3, 8'h00, "R10 unused address");
    #1 chk("R10 idle read zero", reg_rdata, 8'h00);

    // level in forced mode with several pins
    wr(0, 8'h3F);
    wr(2, 8'h00);
    irq_n = 6'b010101;
    step(3);
    chk("R3 multi-pin level", {2'b00, chan_req}, 8'h2A);
    irq_n = '1;
    step(3);
    chk("R9 combined low", {7'd0, irq_any}, 8'h00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule